// File: doc/BRIEF.md
# Two-Channel Serial Converter Read Controller

This block runs on the host side of a small two-input serial analog-to-digital converter. The converter has three wires: a convert-start output driven by this block, a serial clock output, and a serial data input. A client asks for one sample by raising `req_valid` with a channel number while `req_ready` is high. The block signals the channel as a number of pulses. For channel 0 it makes one high pulse on convert-start. For channel 1 it makes two high pulses. It then holds the serial clock at its idle level for the whole conversion time. After that it clocks out eight bits and returns the byte with a single-cycle valid strobe.

All minimum times are given in nanoseconds. Each one becomes a cycle count of the system clock, rounded up, using the `CLK_HZ` parameter. These times are:
- the convert-start high and low widths,
- the conversion wait,
- the half period of the serial clock,
- the recovery gap after the last clock edge.

A parameter picks the idle level of the serial clock, low or high. In both cases the converter changes its data on falling edges and the block samples on rising edges. Convert-start rests low between requests.

Top module: `conv_reader`

## Requirements
- R1: While `rst_n` is low, the outputs hold these values: `conv_o` is 0, `sclk_o` is at its idle level (0 when `SCLK_IDLE_HIGH`=0, 1 when it is 1), `req_ready` is 1, `res_valid` is 0 and `res_data` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the transaction ends. While it is 0, `req_valid` and `req_chan` have no effect on any output.
- R3: When `req_chan`=0, `conv_o` goes high on the accept edge and stays high for exactly HI_CYC cycles. It then falls once and stays low for the rest of the transaction.
- R4: When `req_chan`=1, `conv_o` has this pattern: high for HI_CYC cycles, low for LO_CYC cycles, high for HI_CYC cycles, then low. This gives two falling edges in total.
- R5: From the last falling edge of `conv_o`, `sclk_o` stays at its idle level for exactly CONV_CYC cycles.
- R6: After the conversion wait, `sclk_o` runs through 16 half periods of HALF_CYC cycles each, and then returns to idle. With idle low, the first edge is rising. With idle high, the first edge is falling. Either way there are 8 rising edges.
- R7: `sdi_i` is sampled at each rising edge of `sclk_o`. The first sample is the most significant bit. The 8 samples form `res_data` as an unsigned straight-binary value.
- R8: `res_valid` is high for one cycle, in the cycle right after the 16th half period. `res_data` changes only at that point and holds its value until the next result.
- R9: After `res_valid`, `req_ready` stays 0 for GAP_CYC more cycles. So the next rise of `conv_o` comes at least GAP_CYC cycles after the last edge of `sclk_o`.
- R10: Each cycle count is ceil(ns × CLK_HZ / 1e9), with a minimum of 1. At the default of 125 MHz, HI_CYC=10 (75 ns), LO_CYC=10 (75 ns), CONV_CYC=938 (7500 ns), HALF_CYC=13 (100 ns) and GAP_CYC=7 (50 ns).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Sample request |
| req_chan | input | 1 | Channel to convert (0 or 1) |
| req_ready | output | 1 | High while a request can be accepted |
| conv_o | output | 1 | Convert-start line to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| sdi_i | input | 1 | Serial data from the converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | DATA_W | Captured conversion result |

## Verification
The hardest case to reach is a request line that stays high while the block is busy. Two outcomes must hold in that case. The block must neither restart nor change the channel in the middle of a transaction. It must also take the next request on the first cycle it is idle again, back to back. To reach this, the stimulus holds `req_valid` high for most of one transaction and toggles `req_chan` on every cycle. A second sequence keeps the request high across two transactions in a row, with different channels and data. A second instance, built with a high idle clock, receives the same stimulus, so the falling-first edge order is tested on identical traffic.

// File: rtl/conv_reader_pkg.sv
package conv_reader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CS_HI,
    ST_CS_LO,
    ST_CONV,
    ST_SCK,
    ST_GAP
  } rd_state_e;

  // Round a duration up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cycles(input longint unsigned clk_hz,
                                               input longint unsigned ns);
    longint unsigned c;
    c = (ns * clk_hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 64'd0) c = 64'd1;
    return 32'(c);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/conv_reader_timer.sv
module conv_reader_timer #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_n;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_n  = load ? load_val : (cnt_q - TW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/conv_reader_sclk.sv
module conv_reader_sclk #(
  parameter int HW         = 4,
  parameter bit IDLE_HIGH  = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_sck_n,
  input  logic [HW-1:0] half_n,
  output logic          sclk_o,
  output logic          rise_o
);

  logic lvl_n;
  logic sclk_q;

  generate
    if (IDLE_HIGH) begin : g_idle_hi
      // Even half periods low, odd ones high: falling edge first.
      assign lvl_n = in_sck_n ? half_n[0] : 1'b1;
    end else begin : g_idle_lo
      // Even half periods high, odd ones low: rising edge first.
      assign lvl_n = in_sck_n ? ~half_n[0] : 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= IDLE_HIGH;
    end else begin
      sclk_q <= lvl_n;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = lvl_n & ~sclk_q;

endmodule

// File: rtl/conv_reader_shift.sv
module conv_reader_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_i,
  output logic [DATA_W-1:0] word_o
);

  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_n;

  always_comb begin
    sh_n = {sh_q[DATA_W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (shift_en) begin
      sh_q <= sh_n;
    end
  end

  assign word_o = sh_q;

endmodule

// File: rtl/conv_reader.sv
module conv_reader
  import conv_reader_pkg::*;
#(
  parameter longint unsigned CLK_HZ       = 125_000_000,
  parameter int unsigned     CS_HIGH_NS   = 75,
  parameter int unsigned     CS_SETUP_NS  = 50,
  parameter int unsigned     CS_LOW_NS    = 75,
  parameter int unsigned     CONV_NS      = 7500,
  parameter int unsigned     SCLK_HALF_NS = 100,
  parameter int unsigned     GAP_NS       = 50,
  parameter bit              SCLK_IDLE_HIGH = 1'b0,
  parameter int              DATA_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_chan,
  output logic              req_ready,
  output logic              conv_o,
  output logic              sclk_o,
  input  logic              sdi_i,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data
);

  localparam int unsigned HI_CYC   = ns_to_cycles(CLK_HZ, max2(CS_HIGH_NS, CS_SETUP_NS));
  localparam int unsigned LO_CYC   = ns_to_cycles(CLK_HZ, CS_LOW_NS);
  localparam int unsigned CONV_CYC = ns_to_cycles(CLK_HZ, CONV_NS);
  localparam int unsigned HALF_CYC = ns_to_cycles(CLK_HZ, SCLK_HALF_NS);
  localparam int unsigned GAP_CYC  = ns_to_cycles(CLK_HZ, GAP_NS);
  localparam int unsigned MAX_CYC  = max2(max2(HI_CYC, LO_CYC),
                                          max2(max2(CONV_CYC, HALF_CYC), GAP_CYC));
  localparam int TW     = $clog2(MAX_CYC + 1);
  localparam int NHALF  = 2 * DATA_W;
  localparam int HW     = $clog2(NHALF);

  localparam logic [TW-1:0] HI_LD   = TW'(HI_CYC - 1);
  localparam logic [TW-1:0] LO_LD   = TW'(LO_CYC - 1);
  localparam logic [TW-1:0] CONV_LD = TW'(CONV_CYC - 1);
  localparam logic [TW-1:0] HALF_LD = TW'(HALF_CYC - 1);
  localparam logic [TW-1:0] GAP_LD  = TW'(GAP_CYC - 1);
  localparam logic [HW-1:0] LAST_HALF = HW'(NHALF - 1);

  rd_state_e         state_q, state_n;
  logic              pend_q, pend_n;
  logic [HW-1:0]     half_q, half_n;
  logic              tm_load;
  logic [TW-1:0]     tm_val;
  logic              tm_done;
  logic              fin;
  logic              cs_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              sck_rise;
  logic [DATA_W-1:0] shift_word;

  // Next-state logic
  always_comb begin
    state_n = state_q;
    pend_n  = pend_q;
    half_n  = half_q;
    tm_load = 1'b0;
    tm_val  = '0;
    fin     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_n = ST_CS_HI;
          pend_n  = req_chan;
          tm_load = 1'b1;
          tm_val  = HI_LD;
        end
      end
      ST_CS_HI: begin
        if (tm_done) begin
          tm_load = 1'b1;
          if (pend_q) begin
            state_n = ST_CS_LO;
            tm_val  = LO_LD;
          end else begin
            state_n = ST_CONV;
            tm_val  = CONV_LD;
          end
        end
      end
      ST_CS_LO: begin
        if (tm_done) begin
          state_n = ST_CS_HI;
          pend_n  = 1'b0;
          tm_load = 1'b1;
          tm_val  = HI_LD;
        end
      end
      ST_CONV: begin
        if (tm_done) begin
          state_n = ST_SCK;
          half_n  = '0;
          tm_load = 1'b1;
          tm_val  = HALF_LD;
        end
      end
      ST_SCK: begin
        if (tm_done) begin
          tm_load = 1'b1;
          if (half_q == LAST_HALF) begin
            state_n = ST_GAP;
            tm_val  = GAP_LD;
            fin     = 1'b1;
          end else begin
            half_n  = half_q + HW'(1);
            tm_val  = HALF_LD;
          end
        end
      end
      ST_GAP: begin
        if (tm_done) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      half_q  <= '0;
      cs_q    <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_n;
      pend_q  <= pend_n;
      half_q  <= half_n;
      cs_q    <= (state_n == ST_CS_HI);
      valid_q <= fin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (fin) begin
      data_q <= shift_word;
    end
  end

  conv_reader_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tm_load),
    .load_val (tm_val),
    .done     (tm_done)
  );

  conv_reader_sclk #(.HW(HW), .IDLE_HIGH(SCLK_IDLE_HIGH)) u_sclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_sck_n (state_n == ST_SCK),
    .half_n   (half_n),
    .sclk_o   (sclk_o),
    .rise_o   (sck_rise)
  );

  conv_reader_shift #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (sck_rise),
    .bit_i    (sdi_i),
    .word_o   (shift_word)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign conv_o    = cs_q;
  assign res_valid = valid_q;
  assign res_data  = data_q;

endmodule

// File: rtl/conv_reader_chk.sv
module conv_reader_chk #(
  parameter int unsigned CONV_CYC  = 938,
  parameter int unsigned GAP_CYC   = 7,
  parameter bit          IDLE_HIGH = 1'b0,
  parameter int          DATA_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              conv_o,
  input logic              sclk_o,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data
);

  logic        cs_q;
  logic        sck_q;
  int unsigned fall_cnt;
  int unsigned edge_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b0;
      sck_q    <= IDLE_HIGH;
      fall_cnt <= 0;
      edge_cnt <= GAP_CYC;
    end else begin
      cs_q  <= conv_o;
      sck_q <= sclk_o;
      if (cs_q && !conv_o) fall_cnt <= 1;
      else if (fall_cnt != 32'hFFFF_FFFF) fall_cnt <= fall_cnt + 1;
      if (sck_q != sclk_o) edge_cnt <= 1;
      else if (edge_cnt != 32'hFFFF_FFFF) edge_cnt <= edge_cnt + 1;
    end
  end

  // R2: an idle block drives nothing towards the converter
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!conv_o && (sclk_o == IDLE_HIGH)));

  // R5: no clock activity while convert-start is high
  p_cs_no_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_o |-> (sclk_o == IDLE_HIGH));

  // R5: any clock edge comes at least the conversion wait after the last falling edge
  p_conv_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o != sck_q) |-> (fall_cnt >= CONV_CYC));

  // R9: convert-start only rises after the recovery gap
  p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_o) |-> (edge_cnt >= GAP_CYC));

  // R8: valid is a single-cycle pulse
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R8: result only changes together with valid
  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_data));

  // R9: valid falls inside the busy window
  p_valid_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

endmodule

bind conv_reader conv_reader_chk #(
  .CONV_CYC  (CONV_CYC),
  .GAP_CYC   (GAP_CYC),
  .IDLE_HIGH (SCLK_IDLE_HIGH),
  .DATA_W    (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .conv_o    (conv_o),
  .sclk_o    (sclk_o),
  .res_valid (res_valid),
  .res_data  (res_data)
);

// File: tb/tb_conv_reader.sv
module tb_conv_reader;

  // R10: expected cycle counts at 125 MHz (8 ns), rounded up
  localparam int HI   = 10;
  localparam int LO   = 10;
  localparam int CONV = 938;
  localparam int HALF = 13;
  localparam int GAP  = 7;
  localparam int NB   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_chan = 1'b0;
  logic sdi0 = 1'b0;
  logic sdi3 = 1'b0;

  logic       rdy0, cs0, sck0, val0;
  logic [7:0] dat0;
  logic       rdy3, cs3, sck3, val3;
  logic [7:0] dat3;

  always #4 clk = ~clk;

  conv_reader dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
    .req_ready(rdy0), .conv_o(cs0), .sclk_o(sck0), .sdi_i(sdi0),
    .res_valid(val0), .res_data(dat0)
  );

  conv_reader #(.SCLK_IDLE_HIGH(1'b1)) dut3 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
    .req_ready(rdy3), .conv_o(cs3), .sclk_o(sck3), .sdi_i(sdi3),
    .res_valid(val3), .res_data(dat3)
  );

  integer     errs = 0;
  integer     checks = 0;
  integer     mt = -1;
  integer     mch = 0;
  integer     n_acc = 0;
  logic [7:0] dev_byte = 8'h00;
  logic [7:0] cur = 8'h00;
  logic [7:0] last_res = 8'h00;
  integer     idx0 = 0, idx3 = 0;
  logic       seen0 = 1'b0, seen3 = 1'b0, pk0 = 1'b0, pk3 = 1'b1;

  function automatic integer t_sck(input integer ch);
    return (ch != 0) ? (2*HI + LO + CONV) : (HI + CONV);
  endfunction

  function automatic integer t_conv(input integer ch);
    return (ch != 0) ? (2*HI + LO) : HI;
  endfunction

  function automatic logic exp_cs(input integer t, input integer ch);
    if (t < 0) return 1'b0;
    if (t < HI) return 1'b1;
    if (ch == 0) return 1'b0;
    if (t < HI + LO) return 1'b0;
    if (t < 2*HI + LO) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic exp_sck(input integer t, input integer ch, input logic idle);
    integer s, h;
    s = t_sck(ch);
    if (t >= 0 && t >= s && t < s + 2*NB*HALF) begin
      h = (t - s) / HALF;
      return idle ? ((h % 2) == 1) : ((h % 2) == 0);
    end
    return idle;
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag,
                     input string what);
    checks = checks + 1;
    if (act !== exp) begin
      errs = errs + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference model: advances once per rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mt = -1;
    end else if (mt >= 0) begin
      mt = mt + 1;
      if (mt == t_sck(mch) + 2*NB*HALF) last_res = cur;
      if (mt == t_sck(mch) + 2*NB*HALF + GAP) mt = -1;
    end else if (req_valid) begin
      mt    = 0;
      mch   = req_chan ? 1 : 0;
      cur   = dev_byte;
      n_acc = n_acc + 1;
    end
  end

  // Compare on falling edges, then update the converter models
  always @(negedge clk) begin
    string tcs, tsk, trd;
    if (!rst_n) begin
      chk({7'd0, cs0}, 8'd0, "R1", "conv_o in reset");
      chk({7'd0, sck0}, 8'd0, "R1", "sclk idle-low in reset");
      chk({7'd0, sck3}, 8'd1, "R1", "sclk idle-high in reset");
      chk({7'd0, rdy0}, 8'd1, "R1", "ready in reset");
      chk({7'd0, val0}, 8'd0, "R1", "valid in reset");
      chk(dat0, 8'd0, "R1", "data in reset");
    end else begin
      tcs = (mch != 0) ? "R4" : "R3";
      tsk = (mt >= t_conv(mch) && mt < t_sck(mch)) ? "R5" : "R6";
      trd = (mt >= t_sck(mch) + 2*NB*HALF) ? "R9" : "R2";
      chk({7'd0, cs0}, {7'd0, exp_cs(mt, mch)}, tcs, "conv_o mode0");
      chk({7'd0, cs3}, {7'd0, exp_cs(mt, mch)}, tcs, "conv_o mode3");
      chk({7'd0, sck0}, {7'd0, exp_sck(mt, mch, 1'b0)}, tsk, "sclk mode0");
      chk({7'd0, sck3}, {7'd0, exp_sck(mt, mch, 1'b1)}, tsk, "sclk mode3");
      chk({7'd0, rdy0}, {7'd0, (mt < 0)}, trd, "ready mode0");
      chk({7'd0, rdy3}, {7'd0, (mt < 0)}, trd, "ready mode3");
      chk({7'd0, val0}, {7'd0, (mt == t_sck(mch) + 2*NB*HALF)}, "R8", "valid mode0");
      chk({7'd0, val3}, {7'd0, (mt == t_sck(mch) + 2*NB*HALF)}, "R8", "valid mode3");
      chk(dat0, last_res, "R7", "data mode0");
      chk(dat3, last_res, "R7", "data mode3");
    end
    // Converter models: data advances on a falling edge that follows a rising one
    if (mt == 0) begin
      idx0 = 0; idx3 = 0; seen0 = 1'b0; seen3 = 1'b0;
    end
    if (!pk0 && sck0) seen0 = 1'b1;
    else if (pk0 && !sck0 && seen0) idx0 = idx0 + 1;
    pk0 = sck0;
    if (!pk3 && sck3) seen3 = 1'b1;
    else if (pk3 && !sck3 && seen3) idx3 = idx3 + 1;
    pk3 = sck3;
    sdi0 = (idx0 < 8) ? cur[7 - idx0] : 1'b0;
    sdi3 = (idx3 < 8) ? cur[7 - idx3] : 1'b0;
  end

  task automatic wait_idle();
    @(negedge clk);
    while (mt >= 0) @(negedge clk);
  endtask

  task automatic txn(input logic ch, input logic [7:0] b);
    wait_idle();
    dev_byte  = b;
    req_chan  = ch;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
  endtask

  initial begin
    integer k;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R3 R4 R6 R7: both channels, assorted bit patterns
    txn(1'b0, 8'hA5);
    txn(1'b1, 8'h5A);
    txn(1'b0, 8'h00);
    txn(1'b1, 8'hFF);
    txn(1'b0, 8'h80);
    txn(1'b1, 8'h01);
    // R2: request held high and channel toggled while busy
    dev_byte  = 8'h96;
    req_chan  = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 700; i++) begin
      req_chan = ~req_chan;
      @(negedge clk);
    end
    req_valid = 1'b0;
    wait_idle();
    // R9 R2: back-to-back requests, the second taken on the first idle cycle
    k = n_acc;
    dev_byte  = 8'h3C;
    req_chan  = 1'b1;
    req_valid = 1'b1;
    while (n_acc < k + 1) @(negedge clk);
    dev_byte = 8'hC3;
    req_chan = 1'b0;
    while (n_acc < k + 2) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs + 1, checks + 1);
    $finish;
  end

endmodule